// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two tables. The first table is selected by the branch address and holds a short shift register of that branch's own recent outcomes. The value of that shift register selects an entry in a shared second table of 2-bit saturating counters. The upper bit of that counter is the predicted direction. Because the counter is chosen by outcome pattern rather than by address, a loop with a fixed trip count learns its exit: the pattern seen just before the last iteration maps to its own counter, which trains toward not-taken.

The predict side is purely combinational. A fetch stage presents a branch address and receives the predicted direction together with the history value that produced it. The fetch stage keeps that history with the branch. When the branch resolves, the update side receives the address, the real outcome and the saved history. On the next clock edge the update shifts the outcome into the branch's history entry and trains the counter that the saved history selects.

Top module: `lhp_top`

## Requirements
- R1: After a synchronous reset, every history entry reads 0 and every counter is in state 01 (weakly not-taken), so every address predicts not-taken with a reported history of 0.
- R2: The history entry is selected by address bits [9:2] only. Two addresses that differ only in other bits report the same history and the same prediction.
- R3: An accepted update shifts the selected history entry left by one place, drops its oldest bit and puts the outcome in bit 0 (1 = taken, 0 = not taken). The new value is visible on the predict outputs after that clock edge.
- R4: An update trains the counter at the history value supplied with the update, not the counter at the branch's current history.
- R5: A taken outcome moves a counter up one state (00→01→10→11) and leaves a counter at 11 unchanged.
- R6: A not-taken outcome moves a counter down one state (11→10→01→00) and leaves a counter at 00 unchanged.
- R7: The prediction is taken exactly when the selected counter is 10 or 11, that is, when its upper bit is 1.
- R8: While the update-valid input is low, neither table changes, whatever the other update inputs carry.
- R9: A branch repeatedly running 7 taken outcomes and then 1 not-taken outcome is predicted correctly at every step, its exit included, once a few rounds of training have passed.
- R10: An update changes only the history entry of its own address and only the counter at its supplied history. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W (32) | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W (8) | History value used for this prediction |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W (8) | History returned when this branch was predicted |

## Verification
The embedded properties assume the update port carries at most one update per cycle and that the inputs are known after reset. They also assume the update-side history may be any value, because the counter checks follow whatever index is supplied. The stimulus holds to this. It drives every input from the negative clock edge, gives the update history either the value the branch was actually predicted with or a random value to exercise R4, and keeps the address pool to 16 index values so that entries are reused and aliased often. A bench-side model of both tables, updated only when the strobe is high, provides every expected value.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    // Direction counter states; upper bit is the predicted direction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_INIT = CTR_WEAK_NT;

    // One saturating training step.
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_state_e'(2'(cur + 2'd1));
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_state_e'(2'(cur - 2'd1));
        end
        return nxt;
    endfunction

    function automatic logic ctr_dir(input ctr_state_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) hist_q[e] <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= {hist_q[wr_idx][HIST_W-2:0], wr_taken};
        end
    end

    assign rd_hist = hist_q[rd_idx];

    // R3
    hist_insert_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_idx != $past(wr_idx)) || (rd_hist[0] == $past(wr_taken)));

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_idx != $past(rd_idx)) || $stable(rd_hist));

endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_state_e        rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    localparam int ENTRIES = 1 << HIST_W;

    ctr_state_e ctr_q [ENTRIES];
    ctr_state_e wr_old;

    assign wr_old = ctr_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_next(wr_old, wr_taken);
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    // R1
    ctr_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_ctr == CTR_WEAK_NT));

    // R5
    ctr_up_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=>
            (ctr_q[$past(wr_idx)] > $past(wr_old)) ||
            (($past(wr_old) == CTR_STRONG_T) && (ctr_q[$past(wr_idx)] == CTR_STRONG_T)));

    // R6
    ctr_down_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=>
            (ctr_q[$past(wr_idx)] < $past(wr_old)) ||
            (($past(wr_old) == CTR_STRONG_NT) && (ctr_q[$past(wr_idx)] == CTR_STRONG_NT)));

endmodule

// File: rtl/lhp_top.sv
module lhp_top
    import lhp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 8,
    parameter int HIST_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);
    logic [IDX_W-1:0] pred_idx;
    logic [IDX_W-1:0] upd_idx;
    ctr_state_e       pred_ctr;

    assign pred_idx = pred_pc[IDX_LSB +: IDX_W];
    assign upd_idx  = upd_pc[IDX_LSB +: IDX_W];

    lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_idx),
        .rd_hist  (pred_hist),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    lhp_ctr_table #(.HIST_W(HIST_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_hist),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_hist),
        .wr_taken (upd_taken)
    );

    assign pred_taken = ctr_dir(pred_ctr);

endmodule

// File: tb/lhp_top_tb_top.sv
module lhp_top_tb_top;
    localparam int PC_W = 32, IDX_LSB = 2, IDX_W = 8, HIST_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic [PC_W-1:0]   pred_pc;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              upd_valid;
    logic [PC_W-1:0]   upd_pc;
    logic              upd_taken;
    logic [HIST_W-1:0] upd_hist;

    lhp_top #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [HIST_W-1:0] m_hist [1 << IDX_W];
    logic [1:0]        m_ctr  [1 << HIST_W];

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return pc[IDX_LSB +: IDX_W];
    endfunction

    function automatic logic [1:0] step(input logic [1:0] c, input logic t);
        if (t)  return (c == 2'b11) ? c : c + 2'd1;
        else    return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < (1 << IDX_W); e++)  m_hist[e] = '0;
        for (int e = 0; e < (1 << HIST_W); e++) m_ctr[e]  = 2'b01;
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input logic t, input logic [HIST_W-1:0] h);
        m_ctr[h] = step(m_ctr[h], t);
        m_hist[idx_of(pc)] = {m_hist[idx_of(pc)][HIST_W-2:0], t};
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample predict outputs for pc against the model.
    task automatic probe(input string req, input logic [PC_W-1:0] pc);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk(req, int'(pred_hist), int'(m_hist[idx_of(pc)]));
        chk(req, int'(pred_taken), int'(m_ctr[m_hist[idx_of(pc)]][1]));
    endtask

    task automatic do_update(input logic [PC_W-1:0] pc, input logic t, input logic [HIST_W-1:0] h);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
        @(posedge clk);
        #1;
        model_update(pc, t, h);
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    localparam logic [PC_W-1:0] PC_A = 32'h0000_1010;
    localparam logic [PC_W-1:0] PC_C = 32'h0000_2084;
    localparam logic [PC_W-1:0] PC_L = 32'h0000_33F0;

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_hist = '0;
        model_reset();
        do_reset();

        // R1: literal reset values at several addresses
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pred_pc = $urandom();
            #1;
            chk("R1", int'(pred_hist), 0);
            chk("R1", int'(pred_taken), 0);
        end

        // R5/R6/R7/R4: C trains counter 0, A (history 0) observes it
        do_update(PC_C, 1'b1, 8'h00); probe("R7", PC_A);
        do_update(PC_C, 1'b1, 8'h00); probe("R5", PC_A);
        do_update(PC_C, 1'b1, 8'h00); probe("R5", PC_A);
        do_update(PC_C, 1'b0, 8'h00); probe("R5", PC_A);
        do_update(PC_C, 1'b0, 8'h00); probe("R7", PC_A);
        do_update(PC_C, 1'b0, 8'h00); probe("R6", PC_A);
        do_update(PC_C, 1'b0, 8'h00); probe("R6", PC_A);
        do_update(PC_C, 1'b1, 8'h00); probe("R6", PC_A);
        probe("R4", PC_C);
        probe("R3", PC_C);

        // R2: aliasing across bits outside [9:2]
        probe("R2", PC_C ^ 32'hFFFF_F003);
        probe("R2", PC_A | 32'h8000_0C02);

        // R8: strobe low with live-looking inputs
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = PC_A; upd_taken = 1'b1; upd_hist = 8'h00;
        repeat (3) @(negedge clk);
        probe("R8", PC_A);
        probe("R8", PC_C);

        // R10: updates at other addresses leave A and its counter alone
        for (int k = 0; k < 6; k++) do_update(PC_L, 1'b1, 8'h5A);
        probe("R10", PC_A);
        probe("R10", PC_C);

        // R9: fixed 8-trip loop after a fresh reset
        do_reset();
        probe("R1", PC_L);
        for (int r = 0; r < 6; r++) begin
            for (int it = 0; it < 8; it++) begin
                logic outc;
                logic [HIST_W-1:0] h;
                outc = (it != 7);
                @(negedge clk);
                pred_pc = PC_L;
                #1;
                h = pred_hist;
                chk("R9", int'(pred_hist), int'(m_hist[idx_of(PC_L)]));
                if (r >= 3) chk("R9", int'(pred_taken), int'(outc));
                do_update(PC_L, outc, h);
            end
        end

        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            logic [PC_W-1:0] pc;
            logic [PC_W-1:0] up;
            logic v;
            pc = ($urandom() & ~32'h0000_03FC) | (32'($urandom_range(0, 15)) << 6);
            up = ($urandom() & ~32'h0000_03FC) | (32'($urandom_range(0, 15)) << 6);
            @(negedge clk);
            pred_pc = pc;
            v = ($urandom_range(0, 3) != 0);
            upd_valid = v; upd_pc = up; upd_taken = $urandom_range(0, 1);
            upd_hist = ($urandom_range(0, 1) != 0) ? m_hist[idx_of(up)] : 8'($urandom());
            #1;
            chk("R3", int'(pred_hist), int'(m_hist[idx_of(pc)]));
            chk("R4", int'(pred_taken), int'(m_ctr[m_hist[idx_of(pc)]][1]));
            @(posedge clk);
            #1;
            if (v) model_update(up, upd_taken, upd_hist);
        end
        @(negedge clk);
        upd_valid = 1'b0;
        probe("R10", PC_A);

        summary();
        $finish;
    end
endmodule